// File: doc/BRIEF.md
# Serial Service-Bus Command Frame Decoder

This block listens to a two-wire serial service bus made of a bus clock and an active-low data line. It turns each command frame from the bus master into parallel fields. A frame opens with a start bit, then carries a two-bit target ID and a variable-length command code. Address commands then carry a direction bit, an optional sign bit, the address, a size bit and, for writes, the write data. Every frame closes with a four-bit CRC. The decoder reports the command, the target, the direction, the raw address, the transfer size, the write data and the CRC result, all together under a single-cycle valid strobe.

The bus is oversampled by the system clock. A rising edge of the bus clock is detected in the system clock domain, and each such edge delivers one bit to the decoder. A separate run counter watches for the long all-ones condition that resets the bus. After that condition the decoder stays deaf until the line has been low for a turnaround interval. Resolving relative addresses and decoding slave replies are left to the logic downstream.

Top module: `sbus_frame_decoder`

## Requirements
- R1: A bit is taken only at a rising edge of `busClk`, seen on a system clock edge, and its logic value is the inverse of `busDataN`. Changes of `busDataN` while `busClk` stays low are ignored. While idle, a logic-0 bit is skipped and a logic-1 bit is the start bit of a frame.
- R2: The two bits after the start bit form `targetId`, and the first of them is bit 0.
- R3: Command codes arrive MSB first and map to `cmd` as follows: 100 gives 0 (absolute address), 101 gives 1 (relative address), 11 gives 2 (same address), 010 gives 3 (data poll), 011 gives 4 (error poll) and 001 gives 5 (interrupt poll). The value 6 is reserved for the terminate command of R7.
- R4: Eight command bits that match no code raise `errInvalidCmd` for one cycle, after the eighth bit. No frame is reported, and the decoder returns to idle.
- R5: Address commands carry a direction bit (1 = read), which is reported on `isRead`. A relative command then carries a sign bit, reported on `addrNeg`. The address follows MSB first and is 21, 8 or 2 bits long for absolute, relative and same-address commands, reported right-aligned and zero-extended on `addr`. For polls, `addr`, `isRead` and `addrNeg` are 0.
- R6: The size bit after the address selects the transfer size. A 0 gives byte (`size`=0). A 1 with raw address low bits 01 gives word (`size`=2). A 1 with address bit 0 clear gives halfword (`size`=1). A 1 with low bits 11 on a write raises `errSize` for one cycle and returns to idle without a frame.
- R7: A read whose raw address low bits are 11 and whose size bit is 1 is a terminate command. It is reported as `cmd`=6 with `isRead`=0, carries no data, and goes straight to the CRC.
- R8: A write carries 8, 16 or 32 data bits after the size bit, MSB first, reported zero-extended on `wdata`. Reads, polls and terminate carry no data and report `wdata`=0.
- R9: The CRC starts at 0. For each bit from the start bit to the last payload bit, it advances as fb = c[3]^bit, next = {c[2], c[1]^fb, c[0]^fb, fb}. `crcOk` is 1 when the four CRC bits, received MSB first, equal that value.
- R10: `frameValid` is high for exactly one system cycle, the cycle after the edge that takes the last CRC bit. All frame fields hold their values until the next `frameValid`.
- R11: After BREAK_LEN consecutive logic-1 bits, `breakDet` pulses one cycle after the last of them, in any state. The bus is then ignored until TAR_CYCLES consecutive logic-0 bits have been taken, and a start bit after that is accepted.
- R12: When a run of more than BREAK_LEN logic-1 bits ends with a logic-0 bit, `breakLong` pulses one cycle after that bit. A run of exactly BREAK_LEN does not raise it.
- R13: A synchronous `rst` clears all outputs to 0 and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busClk | input | 1 | Bus clock, bits taken at its rising edge |
| busDataN | input | 1 | Active-low bus data |
| frameValid | output | 1 | One-cycle strobe for a complete frame |
| cmd | output | 3 | Decoded command code |
| targetId | output | 2 | Target ID of the frame |
| isRead | output | 1 | Read direction |
| addrNeg | output | 1 | Sign bit of a relative address |
| addr | output | ADDR_W | Raw address, right-aligned |
| size | output | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| wdata | output | 32 | Write data, right-aligned |
| crcOk | output | 1 | Received CRC matched |
| errInvalidCmd | output | 1 | Unmatched command pulse |
| errSize | output | 1 | Unknown transfer size pulse |
| breakDet | output | 1 | BREAK detected pulse |
| breakLong | output | 1 | Over-long BREAK ended pulse |

## Verification
Every result of this block is decided at a single bus bit: the last CRC bit for a frame, the eighth command bit for an invalid code, the size bit for a size error, the BREAK_LEN-th logic-1 bit for BREAK, and the closing logic-0 bit for an over-long BREAK. Each result appears one system cycle after the system edge that sees the bus clock rise. The bench raises the bus clock on a falling system edge, lowers it on the next falling edge, and samples the outputs at that second falling edge, which lies inside the one-cycle window of the pulse. It samples one bit later to confirm that the pulse has cleared and that the fields have held.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    CMD_ABS   = 3'd0,
    CMD_REL   = 3'd1,
    CMD_SAME  = 3'd2,
    CMD_DPOLL = 3'd3,
    CMD_EPOLL = 3'd4,
    CMD_IPOLL = 3'd5,
    CMD_TERM  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  // strobes from control to datapath, one bit edge at a time
  typedef struct packed {
    logic bitEn;
    logic bitVal;
    logic frameStart;
    logic crcUpd;
    logic shId;
    logic ldDir;
    logic clrDir;
    logic ldSign;
    logic shAddr;
    logic shData;
    logic shCrc;
    logic latch;
  } strb_t;

endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int BREAK_LEN  = 256,
  parameter int TAR_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busClk,
  input  logic       busDataN,
  input  logic [1:0] rawLow,
  input  logic       rdBit,
  output strb_t      strb,
  output cmd_e       cmdOut,
  output size_e      sizeOut,
  output logic       frameValid,
  output logic       errInvalidCmd,
  output logic       errSize,
  output logic       breakDet,
  output logic       breakLong
);

  localparam int REL_W   = 8;
  localparam int SAME_W  = 2;
  localparam int MAX_LEN = (ADDR_W > 32) ? ADDR_W : 32;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int RUN_W   = $clog2(BREAK_LEN + 2);
  localparam int TAR_W   = $clog2(TAR_CYCLES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_CMD, ST_DIR, ST_SIGN,
    ST_ADDR, ST_SIZE, ST_DATA, ST_CRC, ST_BRK
  } st_e;

  st_e              st;
  logic             busClkQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] addrLen;
  logic [CNT_W-1:0] dataLen;
  logic [2:0]       code;
  cmd_e             cmdW;
  size_e            sizeW;
  logic [RUN_W-1:0] runCnt;
  logic [TAR_W-1:0] tarCnt;

  logic       bitEn, bitVal, breakHit;
  logic [2:0] codeNxt;
  logic       cmdHit;
  cmd_e       cmdNxt;
  logic       isTerm, szOk;
  size_e      szNxt;

  assign bitEn    = busClk & ~busClkQ;
  assign bitVal   = ~busDataN;
  assign breakHit = bitEn & bitVal & (runCnt == RUN_W'(BREAK_LEN - 1));
  assign codeNxt  = {code[1:0], bitVal};

  // prefix-free command match
  always_comb begin
    cmdHit = 1'b0;
    cmdNxt = CMD_ABS;
    if (cnt == CNT_W'(1) && codeNxt[1:0] == 2'b11) begin
      cmdHit = 1'b1;
      cmdNxt = CMD_SAME;
    end else if (cnt == CNT_W'(2)) begin
      cmdHit = 1'b1;
      case (codeNxt)
        3'b100:  cmdNxt = CMD_ABS;
        3'b101:  cmdNxt = CMD_REL;
        3'b010:  cmdNxt = CMD_DPOLL;
        3'b011:  cmdNxt = CMD_EPOLL;
        3'b001:  cmdNxt = CMD_IPOLL;
        default: cmdHit = 1'b0;
      endcase
    end
  end

  // size bit interpretation; terminate wins over size decode
  always_comb begin
    isTerm = rdBit && rawLow == 2'b11 && bitVal;
    szOk   = 1'b1;
    szNxt  = SZ_BYTE;
    if (bitVal) begin
      if (rawLow == 2'b01)  szNxt = SZ_WORD;
      else if (!rawLow[0])  szNxt = SZ_HALF;
      else                  szOk  = 1'b0;
    end
  end

  always_comb begin
    strb        = '0;
    strb.bitEn  = bitEn;
    strb.bitVal = bitVal;
    if (bitEn && !breakHit) begin
      case (st)
        ST_IDLE: strb.frameStart = bitVal;
        ST_ID:   begin strb.crcUpd = 1'b1; strb.shId   = 1'b1; end
        ST_CMD:  strb.crcUpd = 1'b1;
        ST_DIR:  begin strb.crcUpd = 1'b1; strb.ldDir  = 1'b1; end
        ST_SIGN: begin strb.crcUpd = 1'b1; strb.ldSign = 1'b1; end
        ST_ADDR: begin strb.crcUpd = 1'b1; strb.shAddr = 1'b1; end
        ST_SIZE: begin strb.crcUpd = 1'b1; strb.clrDir = isTerm; end
        ST_DATA: begin strb.crcUpd = 1'b1; strb.shData = 1'b1; end
        ST_CRC:  begin strb.shCrc  = 1'b1; strb.latch  = (cnt == CNT_W'(3)); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      busClkQ       <= 1'b0;
      cnt           <= '0;
      addrLen       <= '0;
      dataLen       <= '0;
      code          <= '0;
      cmdW          <= CMD_ABS;
      sizeW         <= SZ_BYTE;
      cmdOut        <= CMD_ABS;
      sizeOut       <= SZ_BYTE;
      frameValid    <= 1'b0;
      errInvalidCmd <= 1'b0;
      errSize       <= 1'b0;
      breakDet      <= 1'b0;
      breakLong     <= 1'b0;
      runCnt        <= '0;
      tarCnt        <= '0;
    end else begin
      busClkQ       <= busClk;
      frameValid    <= 1'b0;
      errInvalidCmd <= 1'b0;
      errSize       <= 1'b0;
      breakDet      <= 1'b0;
      breakLong     <= 1'b0;
      if (bitEn) begin
        if (bitVal) begin
          if (runCnt <= RUN_W'(BREAK_LEN)) runCnt <= runCnt + RUN_W'(1);
        end else begin
          runCnt <= '0;
          if (runCnt > RUN_W'(BREAK_LEN)) breakLong <= 1'b1;
        end
        if (breakHit) begin
          breakDet <= 1'b1;
          st       <= ST_BRK;
          tarCnt   <= '0;
        end else begin
          case (st)
            ST_IDLE: if (bitVal) begin st <= ST_ID; cnt <= '0; end
            ST_ID: begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(1)) begin st <= ST_CMD; cnt <= '0; code <= '0; end
            end
            ST_CMD: begin
              code <= codeNxt;
              cnt  <= cnt + CNT_W'(1);
              if (cmdHit) begin
                cmdW  <= cmdNxt;
                sizeW <= SZ_BYTE;
                cnt   <= '0;
                case (cmdNxt)
                  CMD_ABS:  begin addrLen <= CNT_W'(ADDR_W); st <= ST_DIR; end
                  CMD_REL:  begin addrLen <= CNT_W'(REL_W);  st <= ST_DIR; end
                  CMD_SAME: begin addrLen <= CNT_W'(SAME_W); st <= ST_DIR; end
                  default:  st <= ST_CRC;
                endcase
              end else if (cnt == CNT_W'(7)) begin
                errInvalidCmd <= 1'b1;
                st            <= ST_IDLE;
              end
            end
            ST_DIR: begin
              cnt <= '0;
              st  <= (cmdW == CMD_REL) ? ST_SIGN : ST_ADDR;
            end
            ST_SIGN: st <= ST_ADDR;
            ST_ADDR: begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == addrLen - CNT_W'(1)) begin st <= ST_SIZE; cnt <= '0; end
            end
            ST_SIZE: begin
              cnt <= '0;
              if (isTerm) begin
                cmdW <= CMD_TERM;
                st   <= ST_CRC;
              end else if (!szOk) begin
                errSize <= 1'b1;
                st      <= ST_IDLE;
              end else begin
                sizeW <= szNxt;
                case (szNxt)
                  SZ_WORD: dataLen <= CNT_W'(32);
                  SZ_HALF: dataLen <= CNT_W'(16);
                  default: dataLen <= CNT_W'(8);
                endcase
                st <= rdBit ? ST_CRC : ST_DATA;
              end
            end
            ST_DATA: begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == dataLen - CNT_W'(1)) begin st <= ST_CRC; cnt <= '0; end
            end
            ST_CRC: begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(3)) begin
                frameValid <= 1'b1;
                cmdOut     <= cmdW;
                sizeOut    <= sizeW;
                st         <= ST_IDLE;
              end
            end
            ST_BRK: begin
              if (bitVal) tarCnt <= '0;
              else if (tarCnt == TAR_W'(TAR_CYCLES - 1)) begin st <= ST_IDLE; tarCnt <= '0; end
              else tarCnt <= tarCnt + TAR_W'(1);
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  a_r10_valid_single: assert property (@(posedge clk) disable iff (rst)
    frameValid |=> !frameValid);
  a_r10_valid_after_edge: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> $past(busClk));
  a_r11_break_single: assert property (@(posedge clk) disable iff (rst)
    breakDet |=> !breakDet);
  a_r11_break_on_high: assert property (@(posedge clk) disable iff (rst)
    breakDet |-> !$past(busDataN));
  a_r12_long_on_low: assert property (@(posedge clk) disable iff (rst)
    breakLong |-> $past(busDataN));
  a_r4_r6_outcome_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frameValid, errInvalidCmd, errSize}));

endmodule

// File: rtl/sbus_dp.sv
module sbus_dp
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strb_t             strb,
  output logic [1:0]        rawLow,
  output logic              rdBit,
  output logic [1:0]        targetId,
  output logic              isRead,
  output logic              addrNeg,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              crcOk
);

  logic [3:0]        crc;
  logic [1:0]        idW;
  logic              rdW, sgnW;
  logic [ADDR_W-1:0] addrW;
  logic [DATA_W-1:0] dataW;
  logic [2:0]        crcRx;

  function automatic logic [3:0] crcStep(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2], c[1] ^ fb, c[0] ^ fb, fb};
  endfunction

  assign rawLow = addrW[1:0];
  assign rdBit  = rdW;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc <= '0; idW <= '0; rdW <= 1'b0; sgnW <= 1'b0;
      addrW <= '0; dataW <= '0; crcRx <= '0;
      targetId <= '0; isRead <= 1'b0; addrNeg <= 1'b0;
      addr <= '0; wdata <= '0; crcOk <= 1'b0;
    end else begin
      if (strb.frameStart) begin
        crc   <= crcStep(4'd0, strb.bitVal);
        addrW <= '0;
        dataW <= '0;
        rdW   <= 1'b0;
        sgnW  <= 1'b0;
      end
      if (strb.crcUpd) crc   <= crcStep(crc, strb.bitVal);
      if (strb.shId)   idW   <= {strb.bitVal, idW[1]};
      if (strb.ldDir)  rdW   <= strb.bitVal;
      if (strb.clrDir) rdW   <= 1'b0;
      if (strb.ldSign) sgnW  <= strb.bitVal;
      if (strb.shAddr) addrW <= {addrW[ADDR_W-2:0], strb.bitVal};
      if (strb.shData) dataW <= {dataW[DATA_W-2:0], strb.bitVal};
      if (strb.shCrc)  crcRx <= {crcRx[1:0], strb.bitVal};
      if (strb.latch) begin
        targetId <= idW;
        isRead   <= rdW;
        addrNeg  <= sgnW;
        addr     <= addrW;
        wdata    <= dataW;
        crcOk    <= ({crcRx, strb.bitVal} == crc);
      end
    end
  end

  a_r9_crc_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.bitEn |=> $stable(crc));
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.latch |=> $stable(addr) && $stable(wdata));

endmodule

// File: rtl/sbus_frame_decoder.sv
module sbus_frame_decoder
  import sbus_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int BREAK_LEN  = 256,
  parameter int TAR_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busClk,
  input  logic              busDataN,
  output logic              frameValid,
  output logic [2:0]        cmd,
  output logic [1:0]        targetId,
  output logic              isRead,
  output logic              addrNeg,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        size,
  output logic [31:0]       wdata,
  output logic              crcOk,
  output logic              errInvalidCmd,
  output logic              errSize,
  output logic              breakDet,
  output logic              breakLong
);

  strb_t      strb;
  cmd_e       cmdOut;
  size_e      sizeOut;
  logic [1:0] rawLow;
  logic       rdBit;

  sbus_ctrl #(
    .ADDR_W(ADDR_W), .BREAK_LEN(BREAK_LEN), .TAR_CYCLES(TAR_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .busClk(busClk), .busDataN(busDataN),
    .rawLow(rawLow), .rdBit(rdBit), .strb(strb),
    .cmdOut(cmdOut), .sizeOut(sizeOut), .frameValid(frameValid),
    .errInvalidCmd(errInvalidCmd), .errSize(errSize),
    .breakDet(breakDet), .breakLong(breakLong)
  );

  sbus_dp #(.ADDR_W(ADDR_W), .DATA_W(32)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .rawLow(rawLow), .rdBit(rdBit),
    .targetId(targetId), .isRead(isRead), .addrNeg(addrNeg),
    .addr(addr), .wdata(wdata), .crcOk(crcOk)
  );

  assign cmd  = cmdOut;
  assign size = sizeOut;

  a_r7_term_not_read: assert property (@(posedge clk) disable iff (rst)
    (frameValid && cmd == 3'd6) |-> (!isRead && wdata == '0));

endmodule

// File: tb/sbus_frame_decoder_tb_top.sv
module sbus_frame_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busClk = 1'b0;
  logic        busDataN = 1'b1;
  logic        frameValid, isRead, addrNeg, crcOk;
  logic        errInvalidCmd, errSize, breakDet, breakLong;
  logic [2:0]  cmd;
  logic [1:0]  targetId, size;
  logic [20:0] addr;
  logic [31:0] wdata;

  int nVec = 0;
  int nFail = 0;
  int fvCount = 0;
  logic [3:0] bcrc;

  always #5 clk = ~clk;

  sbus_frame_decoder dut_i (
    .clk(clk), .rst(rst), .busClk(busClk), .busDataN(busDataN),
    .frameValid(frameValid), .cmd(cmd), .targetId(targetId), .isRead(isRead),
    .addrNeg(addrNeg), .addr(addr), .size(size), .wdata(wdata), .crcOk(crcOk),
    .errInvalidCmd(errInvalidCmd), .errSize(errSize),
    .breakDet(breakDet), .breakLong(breakLong)
  );

  always @(negedge clk) if (frameValid) fvCount++;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  id;
    logic        rd;
    logic        sgn;
    logic [20:0] ad;
    logic        sz;
    logic [31:0] dat;
    logic        bad;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{3'd0, 2'b01, 1'b0, 1'b0, 21'h12345, 1'b1, 32'hDEADBEEF, 1'b0},
    '{3'd0, 2'b10, 1'b1, 1'b0, 21'h1ABCD, 1'b0, 32'h0,        1'b0},
    '{3'd1, 2'b11, 1'b0, 1'b1, 21'h000A4, 1'b1, 32'h1234BEEF, 1'b0},
    '{3'd2, 2'b00, 1'b0, 1'b0, 21'h00002, 1'b0, 32'hFFFFFF5A, 1'b0},
    '{3'd2, 2'b01, 1'b1, 1'b0, 21'h00003, 1'b1, 32'h0,        1'b0},
    '{3'd3, 2'b10, 1'b0, 1'b0, 21'h0,     1'b0, 32'h0,        1'b0},
    '{3'd4, 2'b11, 1'b0, 1'b0, 21'h0,     1'b0, 32'h0,        1'b1},
    '{3'd5, 2'b00, 1'b0, 1'b0, 21'h0,     1'b0, 32'h0,        1'b0},
    '{3'd0, 2'b01, 1'b0, 1'b0, 21'h0F0F3, 1'b1, 32'h0,        1'b0},
    '{3'd1, 2'b10, 1'b1, 1'b0, 21'h00051, 1'b1, 32'h0,        1'b1},
    '{3'd0, 2'b11, 1'b1, 1'b0, 21'h1FFFE, 1'b1, 32'h0,        1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crcStep(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2], c[1] ^ fb, c[0] ^ fb, fb};
  endfunction

  task automatic txBit(input logic b, input logic upd);
    if (upd) bcrc = crcStep(bcrc, b);
    @(negedge clk);
    busDataN = ~b;
    busClk   = 1'b1;
    @(negedge clk);
    busClk   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) txBit(1'b0, 1'b0);
  endtask

  task automatic sendFrame(input vec_t v, input logic doChk);
    logic poll, term, unk;
    logic [1:0] expSz;
    logic [3:0] c;
    logic [20:0] expAddr;
    logic [31:0] expData;
    int alen, dlen;
    poll  = (v.kind >= 3'd3);
    term  = !poll && v.rd && v.ad[1:0] == 2'b11 && v.sz;
    unk   = !poll && !term && v.sz && v.ad[1:0] == 2'b11;
    expSz = !v.sz ? 2'd0 : (v.ad[1:0] == 2'b01 ? 2'd2 : 2'd1);
    alen  = (v.kind == 3'd0) ? 21 : (v.kind == 3'd1) ? 8 : 2;
    dlen  = (expSz == 2'd0) ? 8 : (expSz == 2'd1) ? 16 : 32;
    bcrc = 4'd0;
    txBit(1'b1, 1'b1);
    txBit(v.id[0], 1'b1);
    txBit(v.id[1], 1'b1);
    case (v.kind)
      3'd0: begin txBit(1, 1); txBit(0, 1); txBit(0, 1); end
      3'd1: begin txBit(1, 1); txBit(0, 1); txBit(1, 1); end
      3'd2: begin txBit(1, 1); txBit(1, 1); end
      3'd3: begin txBit(0, 1); txBit(1, 1); txBit(0, 1); end
      3'd4: begin txBit(0, 1); txBit(1, 1); txBit(1, 1); end
      default: begin txBit(0, 1); txBit(0, 1); txBit(1, 1); end
    endcase
    if (!poll) begin
      txBit(v.rd, 1'b1);
      if (v.kind == 3'd1) txBit(v.sgn, 1'b1);
      for (int i = alen - 1; i >= 0; i--) txBit(v.ad[i], 1'b1);
      txBit(v.sz, 1'b1);
      if (unk) begin
        if (doChk) begin
          chk("R6 size error flag", {31'd0, errSize}, 32'd1);
          chk("R6 no frame on size error", {31'd0, frameValid}, 32'd0);
        end
        return;
      end
      if (!term && !v.rd) for (int i = dlen - 1; i >= 0; i--) txBit(v.dat[i], 1'b1);
    end
    c = bcrc ^ {3'b000, v.bad};
    for (int i = 3; i >= 0; i--) txBit(c[i], 1'b0);
    expAddr = poll ? 21'd0 : 21'((32'd1 << alen) - 32'd1) & v.ad;
    expData = (poll || term || v.rd) ? 32'd0 : 32'((64'd1 << dlen) - 64'd1) & v.dat;
    if (doChk) begin
      chk("R10 frame strobe", {31'd0, frameValid}, 32'd1);
      chk("R3 R7 command", {29'd0, cmd}, {29'd0, term ? 3'd6 : v.kind});
      chk("R2 target id", {30'd0, targetId}, {30'd0, v.id});
      chk("R5 direction", {31'd0, isRead}, {31'd0, (poll || term) ? 1'b0 : v.rd});
      chk("R5 sign", {31'd0, addrNeg}, {31'd0, (v.kind == 3'd1) ? v.sgn : 1'b0});
      chk("R5 address", {11'd0, addr}, {11'd0, expAddr});
      chk("R8 write data", wdata, expData);
      if (!poll && !term) chk("R6 size", {30'd0, size}, {30'd0, expSz});
      chk("R9 crc result", {31'd0, crcOk}, {31'd0, !v.bad});
      txBit(1'b0, 1'b0);
      chk("R10 strobe one cycle", {31'd0, frameValid}, 32'd0);
      chk("R10 address held", {11'd0, addr}, {11'd0, expAddr});
    end
  endtask

  initial begin
    #(10 * 150000);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int fv0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset frameValid", {31'd0, frameValid}, 32'd0);
    chk("R13 reset flags", {28'd0, errInvalidCmd, errSize, breakDet, breakLong}, 32'd0);
    chk("R13 reset fields", {10'd0, crcOk, addr}, 32'd0);
    idle(2);

    // table walk
    for (int i = 0; i < NV; i++) begin
      sendFrame(VT[i], 1'b1);
      idle(2);
    end

    // R1: data wiggles with bus clock low are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); busDataN = 1'b0;
      @(negedge clk); busDataN = 1'b1;
    end
    fv0 = fvCount;
    idle(2);
    chk("R1 no frame from data wiggle", fvCount - fv0, 0);
    sendFrame(VT[3], 1'b1);
    idle(2);

    // R4 invalid command
    txBit(1, 0); txBit(1, 0); txBit(0, 0);
    for (int i = 0; i < 7; i++) txBit(1'b0, 1'b0);
    chk("R4 no flag before eighth bit", {31'd0, errInvalidCmd}, 32'd0);
    txBit(1'b0, 1'b0);
    chk("R4 invalid command flag", {31'd0, errInvalidCmd}, 32'd1);
    idle(2);
    sendFrame(VT[0], 1'b1);
    idle(2);

    // R13 reset mid-frame
    txBit(1, 0); txBit(1, 0); txBit(0, 0); txBit(1, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R13 reset clears address", {11'd0, addr}, 32'd0);
    sendFrame(VT[2], 1'b1);
    idle(2);

    // R11 break of exactly BREAK_LEN ones
    for (int i = 0; i < 255; i++) txBit(1'b1, 1'b0);
    chk("R11 no break before full run", {31'd0, breakDet}, 32'd0);
    txBit(1'b1, 1'b0);
    chk("R11 break detected", {31'd0, breakDet}, 32'd1);
    txBit(1'b0, 1'b0);
    chk("R12 exact run gives no long flag", {31'd0, breakLong}, 32'd0);
    txBit(1'b0, 1'b0);
    fv0 = fvCount;
    sendFrame('{3'd2, 2'b11, 1'b1, 1'b0, 21'h1, 1'b0, 32'h0, 1'b0}, 1'b0);
    idle(1);
    chk("R11 frame ignored before turnaround", fvCount - fv0, 0);
    idle(4);
    sendFrame(VT[1], 1'b1);
    idle(2);

    // R12 over-long break
    for (int i = 0; i < 258; i++) txBit(1'b1, 1'b0);
    txBit(1'b0, 1'b0);
    chk("R12 long break flag", {31'd0, breakLong}, 32'd1);
    idle(4);
    sendFrame(VT[7], 1'b1);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule